// File: doc/BRIEF.md
# CPU Clock, Ready and Reset Generator

This block takes a fast reference clock and produces the processor timing signals from it. A clock-enable pulse stands for each oscillator period. A select input chooses where that pulse comes from: the crystal path or an external frequency input. A phase state machine divides the chosen pulse train by three. The result is an asymmetric CPU clock that is high for one tick and low for two. A peripheral clock toggles on every CPU clock rise, so it runs at half the CPU clock with equal high and low times. When the external source is in use, a phase-alignment input holds the divider so that several generators can start together.

The block also conditions two slow control paths for the processor. The first is a ready line built from two request channels, each with its own active-low enable. The second is the processor reset, taken from an active-low reset request. Both pass through two capture stages that advance only on CPU clock rises. The processor therefore sees them change only at its own clock edge, and a low ready makes it insert wait states.

The divider state machine has three states. The transitions happen on a tick:
- `PH_HIGH` moves to `PH_LOW_A`.
- `PH_LOW_A` moves to `PH_LOW_B`.
- `PH_LOW_B` moves to `PH_HIGH`.

An active phase hold forces `PH_LOW_B` from any state. Reset also enters `PH_LOW_B`.

Top module: `cpu_timing_gen`

## Requirements
- R1: While `sys_rst_n` is low, `cpu_clk` and `per_clk` are 0, `cpu_ready` is 0 and `cpu_rst` is 1.
- R2: With a tick on every reference cycle, `cpu_clk` is high for one tick period and low for two. Its period is three ticks; in general it is high for one tick interval.
- R3: `per_clk` toggles on the same reference edge where `cpu_clk` rises. It is a 50% clock with a period of six ticks.
- R4: When `freq_sel` is 1, ticks come from `ext_en` and `xtal_en` is ignored. When `freq_sel` is 0, ticks come from `xtal_en` and `ext_en` is ignored. With no tick, both clocks hold their values.
- R5: While `freq_sel` is 1 and `csync` is 1, `cpu_clk` and `per_clk` are held at 0. The first tick after `csync` falls drives both high. While `freq_sel` is 0, `csync` has no effect.
- R6: The raw ready is `(rdy_a AND NOT aen_a_n) OR (rdy_b AND NOT aen_b_n)`, so a channel counts only while its active-low enable is 0.
- R7: `cpu_ready` and `cpu_rst` change only on a reference edge where `cpu_clk` rises. An input held from just after one rise appears at the second rise after it, and not at the first.
- R8: `cpu_rst` is the inverse of `reset_req_n`, with the same two-stage timing as the ready path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; every register runs on it |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the block |
| freq_sel | input | 1 | 1 selects the external tick, 0 the crystal tick |
| xtal_en | input | 1 | Crystal-path tick enable |
| ext_en | input | 1 | External-frequency tick enable |
| csync | input | 1 | Phase hold, effective only while `freq_sel` is 1 |
| reset_req_n | input | 1 | Active-low reset request for the processor |
| rdy_a | input | 1 | Ready request, channel A |
| aen_a_n | input | 1 | Active-low enable for channel A |
| rdy_b | input | 1 | Ready request, channel B |
| aen_b_n | input | 1 | Active-low enable for channel B |
| cpu_clk | output | 1 | Divide-by-three processor clock, one-third high |
| per_clk | output | 1 | Peripheral clock at half of `cpu_clk`, 50% duty |
| cpu_rst | output | 1 | Synchronized active-high processor reset |
| cpu_ready | output | 1 | Synchronized active-high ready |

## Verification
The properties assume that every input is synchronous to `clk_ref`, which is what makes the one-tick high time and the hold-when-idle rule checkable cycle by cycle. The stimulus meets this by changing every input shortly after the falling reference edge. The ready and reset sequences are applied only right after an observed `cpu_clk` rise, so each change falls clearly between two capture edges. The tick source is either held at 1 or pulsed by a counter at a fixed spacing, so the clock shapes the bench expects are exact.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW_A = 2'd1,
        PH_LOW_B = 2'd2
    } ctg_phase_e;
endpackage

// File: rtl/ctg_src_select.sv
module ctg_src_select (
    input  logic freq_sel,
    input  logic xtal_en,
    input  logic ext_en,
    input  logic csync,
    output logic tick,
    output logic hold
);
    // R4: one tick source at a time; R5: alignment only on the external path
    assign tick = freq_sel ? ext_en : xtal_en;
    assign hold = freq_sel & csync;
endmodule

// File: rtl/ctg_phase_fsm.sv
module ctg_phase_fsm
    import ctg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic cpu_clk,
    output logic per_clk,
    output logic rise_en
);
    ctg_phase_e state_q;
    ctg_phase_e state_n;
    logic       cpu_clk_q;
    logic       per_clk_q;

    // next-state decode
    always_comb begin
        state_n = state_q;
        if (hold) begin
            state_n = PH_LOW_B;
        end else if (tick) begin
            unique case (state_q)
                PH_HIGH:  state_n = PH_LOW_A;
                PH_LOW_A: state_n = PH_LOW_B;
                PH_LOW_B: state_n = PH_HIGH;
                default:  state_n = PH_LOW_B;
            endcase
        end
    end

    // a CPU clock rise happens on the tick that leaves PH_LOW_B
    assign rise_en = tick && !hold && (state_q == PH_LOW_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW_B;
        end else begin
            state_q <= state_n;
        end
    end

    // registered outputs, so the clocks leave flops without decode glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_q <= 1'b0;
            per_clk_q <= 1'b0;
        end else begin
            cpu_clk_q <= (state_n == PH_HIGH);
            if (hold) begin
                per_clk_q <= 1'b0;
            end else if (rise_en) begin
                per_clk_q <= ~per_clk_q;
            end
        end
    end

    assign cpu_clk = cpu_clk_q;
    assign per_clk = per_clk_q;
endmodule

// File: rtl/ctg_ready_merge.sv
module ctg_ready_merge #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] rdy,
    input  logic [NUM_CH-1:0] aen_n,
    output logic              any_rdy
);
    logic [NUM_CH-1:0] qual;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            assign qual[g] = rdy[g] & ~aen_n[g];
        end
    endgenerate

    assign any_rdy = |qual;
endmodule

// File: rtl/ctg_edge_sync.sv
module ctg_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        sr[g] <= RST_VAL;
                    end else if (en) begin
                        sr[g] <= d;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        sr[g] <= RST_VAL;
                    end else if (en) begin
                        sr[g] <= sr[g-1];
                    end
                end
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cpu_timing_gen.sv
module cpu_timing_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic sys_rst_n,
    input  logic freq_sel,
    input  logic xtal_en,
    input  logic ext_en,
    input  logic csync,
    input  logic reset_req_n,
    input  logic rdy_a,
    input  logic aen_a_n,
    input  logic rdy_b,
    input  logic aen_b_n,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rst,
    output logic cpu_ready
);
    localparam int NUM_RDY = 2;

    logic               tick;
    logic               hold;
    logic               rise_en;
    logic               raw_rdy;
    logic [NUM_RDY-1:0] rdy_vec;
    logic [NUM_RDY-1:0] aen_vec;

    assign rdy_vec = {rdy_b, rdy_a};
    assign aen_vec = {aen_b_n, aen_a_n};

    ctg_src_select u_sel (
        .freq_sel (freq_sel),
        .xtal_en  (xtal_en),
        .ext_en   (ext_en),
        .csync    (csync),
        .tick     (tick),
        .hold     (hold)
    );

    ctg_phase_fsm u_fsm (
        .clk      (clk_ref),
        .rst_n    (sys_rst_n),
        .tick     (tick),
        .hold     (hold),
        .cpu_clk  (cpu_clk),
        .per_clk  (per_clk),
        .rise_en  (rise_en)
    );

    ctg_ready_merge #(.NUM_CH(NUM_RDY)) u_merge (
        .rdy      (rdy_vec),
        .aen_n    (aen_vec),
        .any_rdy  (raw_rdy)
    );

    ctg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
        .clk      (clk_ref),
        .rst_n    (sys_rst_n),
        .en       (rise_en),
        .d        (raw_rdy),
        .q        (cpu_ready)
    );

    ctg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk      (clk_ref),
        .rst_n    (sys_rst_n),
        .en       (rise_en),
        .d        (~reset_req_n),
        .q        (cpu_rst)
    );
endmodule

// File: rtl/ctg_checker.sv
module ctg_checker (
    input logic clk_ref,
    input logic sys_rst_n,
    input logic freq_sel,
    input logic xtal_en,
    input logic ext_en,
    input logic csync,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_rst,
    input logic cpu_ready
);
    logic chk_tick;
    logic chk_hold;
    assign chk_tick = freq_sel ? ext_en : xtal_en;
    assign chk_hold = freq_sel && csync;

    p_high_one_tick_r2: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
        (cpu_clk && chk_tick && !chk_hold) |=> !cpu_clk);

    p_per_on_rise_r3: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
        (!$past(chk_hold) && !$stable(per_clk)) |-> $rose(cpu_clk));

    p_idle_hold_r4: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
        (!chk_tick && !chk_hold) |=> ($stable(cpu_clk) && $stable(per_clk)));

    p_align_low_r5: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
        chk_hold |=> (!cpu_clk && !per_clk));

    p_sync_on_rise_r7: assert property (@(posedge clk_ref) disable iff (!sys_rst_n)
        !$rose(cpu_clk) |-> ($stable(cpu_ready) && $stable(cpu_rst)));
endmodule

bind cpu_timing_gen ctg_checker u_chk (
    .clk_ref   (clk_ref),
    .sys_rst_n (sys_rst_n),
    .freq_sel  (freq_sel),
    .xtal_en   (xtal_en),
    .ext_en    (ext_en),
    .csync     (csync),
    .cpu_clk   (cpu_clk),
    .per_clk   (per_clk),
    .cpu_rst   (cpu_rst),
    .cpu_ready (cpu_ready)
);

// File: tb/tb_cpu_timing_gen.sv
`timescale 1ns/1ps
module tb_cpu_timing_gen;
    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic freq_sel = 1'b0;
    logic xtal_en = 1'b1;
    logic ext_en = 1'b1;
    logic csync = 1'b0;
    logic reset_req_n = 1'b0;
    logic rdy_a = 1'b0;
    logic aen_a_n = 1'b1;
    logic rdy_b = 1'b0;
    logic aen_b_n = 1'b1;
    logic cpu_clk;
    logic per_clk;
    logic cpu_rst;
    logic cpu_ready;

    int   checks = 0;
    int   fails = 0;
    int   rise_cnt = 0;
    int   ext_period = 1;
    int   ext_cnt = 0;
    logic prev_cpu = 1'b0;
    logic cur_rdy = 1'b0;
    logic cur_rst = 1'b1;
    bit   done = 1'b0;

    typedef struct {
        int    at;
        logic  rdy;
        logic  rst;
        string tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #2.5 clk = ~clk;

    cpu_timing_gen dut (
        .clk_ref     (clk),
        .sys_rst_n   (sys_rst_n),
        .freq_sel    (freq_sel),
        .xtal_en     (xtal_en),
        .ext_en      (ext_en),
        .csync       (csync),
        .reset_req_n (reset_req_n),
        .rdy_a       (rdy_a),
        .aen_a_n     (aen_a_n),
        .rdy_b       (rdy_b),
        .aen_b_n     (aen_b_n),
        .cpu_clk     (cpu_clk),
        .per_clk     (per_clk),
        .cpu_rst     (cpu_rst),
        .cpu_ready   (cpu_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nstep();
        @(negedge clk);
        #1;
    endtask

    // external tick generator: one pulse every ext_period reference cycles
    always @(negedge clk) begin
        if (ext_cnt + 1 >= ext_period) begin
            ext_cnt = 0;
        end else begin
            ext_cnt = ext_cnt + 1;
        end
        ext_en <= (ext_cnt == 0);
    end

    // monitor: counts cpu_clk rises and scores queued ready/reset items
    always @(negedge clk) begin
        if (sys_rst_n && cpu_clk && !prev_cpu) begin
            rise_cnt++;
            while (sbq.size() > 0 && sbq[0].at <= rise_cnt) begin
                if (sbq[0].at == rise_cnt) begin
                    chk(cpu_ready === sbq[0].rdy, {sbq[0].tag, " R7 cpu_ready"},
                        int'(cpu_ready), int'(sbq[0].rdy));
                    chk(cpu_rst === sbq[0].rst, {sbq[0].tag, " R7 cpu_rst"},
                        int'(cpu_rst), int'(sbq[0].rst));
                end
                void'(sbq.pop_front());
            end
        end
        prev_cpu = cpu_clk;
    end

    // driver: change inputs just after a rise, queue the old value for the
    // next rise and the new value for the one after
    task automatic apply(input logic ra, input logic aa, input logic rb,
                         input logic ab, input logic rq, input string tag);
        int   r;
        logic nr;
        logic nrst;
        r = rise_cnt;
        wait (rise_cnt != r);
        rdy_a = ra; aen_a_n = aa; rdy_b = rb; aen_b_n = ab; reset_req_n = rq;
        nr   = (ra && !aa) || (rb && !ab);
        nrst = !rq;
        sbq.push_back('{rise_cnt + 1, cur_rdy, cur_rst, tag});
        sbq.push_back('{rise_cnt + 2, nr, nrst, tag});
        cur_rdy = nr;
        cur_rst = nrst;
    endtask

    task automatic check_shape(input int p, input string tag);
        int   r;
        int   bad_cpu;
        int   bad_per;
        logic p0;
        bad_cpu = 0;
        bad_per = 0;
        r = rise_cnt;
        wait (rise_cnt != r);
        #1;
        p0 = per_clk;
        for (int i = 0; i < 6 * p; i++) begin
            if (i > 0) nstep();
            if (cpu_clk !== ((i % (3 * p)) < p)) bad_cpu++;
            if (per_clk !== ((i < 3 * p) ? p0 : ~p0)) bad_per++;
        end
        chk(bad_cpu == 0, {tag, " R2 cpu_clk shape mismatches"}, bad_cpu, 0);
        chk(bad_per == 0, {tag, " R3 per_clk shape mismatches"}, bad_per, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int r0;
        int chg;
        int bad;
        logic last;

        // R1 reset state
        repeat (4) nstep();
        chk(cpu_clk === 1'b0, "R1 cpu_clk in reset", int'(cpu_clk), 0);
        chk(per_clk === 1'b0, "R1 per_clk in reset", int'(per_clk), 0);
        chk(cpu_ready === 1'b0, "R1 cpu_ready in reset", int'(cpu_ready), 0);
        chk(cpu_rst === 1'b1, "R1 cpu_rst in reset", int'(cpu_rst), 1);
        sys_rst_n = 1'b1;

        // R2/R3 crystal path, tick every cycle
        check_shape(1, "xtal tick every cycle");

        // R5 csync ignored on the crystal path: 30 cycles give 10 rises
        csync = 1'b1;
        nstep();
        r0 = rise_cnt;
        repeat (30) nstep();
        chk(rise_cnt - r0 == 10, "R5 csync ignored when freq_sel=0", rise_cnt - r0, 10);
        csync = 1'b0;

        // R4 external path selected while its ticks are absent -> frozen;
        // crystal ticks must be ignored
        ext_period = 1000;
        repeat (3) nstep();
        freq_sel = 1'b1;
        nstep();
        last = cpu_clk;
        chg = 0;
        repeat (12) begin
            nstep();
            if (cpu_clk !== last) chg++;
            last = cpu_clk;
        end
        chk(chg == 0, "R4 xtal_en ignored when freq_sel=1", chg, 0);

        // R4 external path with a tick every second cycle
        ext_period = 2;
        check_shape(2, "R4 external tick every 2 cycles");

        // R4 crystal path selected with crystal ticks off, external running
        xtal_en = 1'b0;
        ext_period = 1;
        freq_sel = 1'b0;
        nstep();
        last = cpu_clk;
        chg = 0;
        repeat (12) begin
            nstep();
            if (cpu_clk !== last) chg++;
            last = cpu_clk;
        end
        chk(chg == 0, "R4 ext_en ignored when freq_sel=0", chg, 0);
        xtal_en = 1'b1;

        // R5 phase hold on the external path
        freq_sel = 1'b1;
        repeat (4) nstep();
        csync = 1'b1;
        nstep();
        bad = 0;
        repeat (8) begin
            nstep();
            if (cpu_clk !== 1'b0 || per_clk !== 1'b0) bad++;
        end
        chk(bad == 0, "R5 clocks held low during csync", bad, 0);
        csync = 1'b0;
        nstep();
        chk(cpu_clk === 1'b1, "R5 cpu_clk high on first tick after csync", int'(cpu_clk), 1);
        chk(per_clk === 1'b1, "R5 per_clk high on first tick after csync", int'(per_clk), 1);
        nstep();
        chk(cpu_clk === 1'b0, "R5 R2 cpu_clk low second tick after csync", int'(cpu_clk), 0);
        nstep();
        nstep();
        chk(cpu_clk === 1'b1, "R5 R2 cpu_clk high again after three ticks", int'(cpu_clk), 1);

        // R6/R7/R8 scoreboard on the crystal path
        freq_sel = 1'b0;
        apply(0, 1, 0, 1, 1, "R8 reset request released");
        apply(1, 0, 0, 1, 1, "R6 channel A enabled");
        apply(1, 1, 0, 1, 1, "R6 channel A blocked by its enable");
        apply(0, 1, 1, 0, 1, "R6 channel B enabled");
        apply(0, 1, 1, 1, 1, "R6 channel B blocked by its enable");
        apply(1, 0, 1, 0, 1, "R6 both channels ready");
        apply(0, 0, 0, 0, 1, "R6 no channel ready");
        apply(0, 0, 0, 0, 0, "R8 reset request asserted");
        apply(1, 0, 0, 1, 1, "R8 reset released with ready");
        wait (sbq.size() == 0);
        repeat (3) nstep();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule